// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block turns bytes into asynchronous serial frames. A byte written through a one-cycle load strobe lands in a single holding register. When the shifter is idle and the clear-to-send input is asserted (low), the byte moves into the shifter. From there it goes out on the serial line as one start bit, eight data bits with the least significant bit first, and one stop bit. The serial line is high for mark and low for space, and it rests at mark.

Bit timing comes from an external transmit clock. The block samples that clock with the system clock and counts its falling edges. One bit time is 1, 16 or 64 falling edges, as chosen by a rate select input. Two flags go to the host: one says the holding register can take a byte, and the other says every byte loaded so far has been fully sent. An enable input stops the transmitter and forces the line to mark. If clear-to-send drops in the middle of a character, that character still completes.

Top module: `serial_char_tx`

## Requirements
- R1: After reset, `txd` is 1, `holdReady` is 1 and `shiftEmpty` is 1.
- R2: While `txEnable` is 0, `txd` is 1 from the next clock on. Dropping `txEnable` aborts the character in the shifter, and that character does not resume when the enable returns. A byte in the holding register stays there.
- R3: A frame is a start bit of 0, then data bits 0 through 7, then a stop bit of 1. Each bit lasts exactly one bit time, and the line stays at 1 after the stop bit.
- R4: `rateSel` 0 gives 1 falling edge of `txClk` per bit, 1 gives 16, and 2 or 3 give 64. `txd` changes only on the system clock edge where `txClk` is first seen low after being high.
- R5: The falling-edge count restarts from zero while the transmitter is disabled. After enabling, the first bit boundary is the falling edge whose number equals the rate. A byte moves into the shifter at the first bit boundary where the shifter is idle, a byte is held and `ctsN` is 0.
- R6: No character starts while `ctsN` is 1. If `ctsN` rises in the middle of a character, that character is still sent in full, through its stop bit.
- R7: `holdReady` goes to 0 on the clock after a load strobe. It returns to 1 at the bit boundary where the start bit begins.
- R8: `shiftEmpty` is 1 exactly when the shifter is idle and no byte is held. It rises at the boundary that ends the stop bit.
- R9: If a byte is held when a stop bit ends, that boundary begins the next start bit. No idle bit is inserted between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txEnable | input | 1 | Transmitter enable |
| ctsN | input | 1 | Clear to send, active low |
| rateSel | input | 2 | Edges per bit: 0 gives 1, 1 gives 16, 2 or 3 give 64 |
| txClk | input | 1 | External transmit bit clock |
| loadStb | input | 1 | One-cycle strobe that writes `loadData` into the holding register |
| loadData | input | 8 | Byte to send |
| txd | output | 1 | Serial output, 1 is mark |
| holdReady | output | 1 | Holding register can accept a byte |
| shiftEmpty | output | 1 | All loaded bytes have been sent |

## Verification
All 256 byte values are sent at the 1x rate. Checking the line after every falling edge separates bit-order errors, data corruption and framing errors from one another. A few bytes at 16x and 64x, including the rate select value 3, are checked after every single edge, which exposes wrong divider values and changes that come a bit early or late. Clear-to-send is exercised two ways: held high before a byte is loaded, where the byte must wait, and raised in the middle of a character, where the character must still finish. Two further sequences cover back-to-back frames, where a missing or extra idle bit shows up, and disabling the transmitter mid-character, which checks both the forced mark level and the abort.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef struct packed {
    logic xfer;   // move holding register into shifter, emit start bit
    logic shift;  // emit next bit from shifter
  } txStrobeT;
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       txClk,
  input  logic [1:0] rateSel,
  output logic       bitStrobe
);
  localparam int PRESCALE_W = $clog2(DIV_HIGH);
  localparam logic [PRESCALE_W-1:0] MID_M1  = PRESCALE_W'(DIV_MID - 1);
  localparam logic [PRESCALE_W-1:0] HIGH_M1 = PRESCALE_W'(DIV_HIGH - 1);

  logic                  clkQ;
  logic                  fallTick;
  logic [PRESCALE_W-1:0] edgeCnt;
  logic [PRESCALE_W-1:0] divM1;

  always_comb begin
    case (rateSel)
      2'd0:    divM1 = '0;
      2'd1:    divM1 = MID_M1;
      default: divM1 = HIGH_M1;
    endcase
  end

  assign fallTick = clkQ & ~txClk;

  always_ff @(posedge clk) begin
    if (rst) clkQ <= 1'b0;
    else     clkQ <= txClk;
  end

  always_ff @(posedge clk) begin
    if (rst || !en)
      edgeCnt <= '0;
    else if (fallTick)
      edgeCnt <= (edgeCnt >= divM1) ? '0 : edgeCnt + 1'b1;
  end

  assign bitStrobe = en & fallTick & (edgeCnt >= divM1);

  p_strobe_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    bitStrobe |-> ($past(txClk) && !txClk));
  p_cnt_cleared_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (edgeCnt == '0));
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     ctsN,
  input  logic     bitStrobe,
  input  logic     holdFull,
  output txStrobeT strobes,
  output logic     busy
);
  localparam int FRAME_LEFT = DATA_BITS + 1;  // data bits plus stop bit
  localparam int CNT_W      = $clog2(FRAME_LEFT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FRAME_LEFT);

  logic [CNT_W-1:0] bitCnt;
  logic             lastBit;

  assign lastBit = busy && (bitCnt == '0);

  always_comb begin
    strobes = '0;
    if (bitStrobe && en) begin
      if (busy && !lastBit)
        strobes.shift = 1'b1;
      else if (holdFull && !ctsN)
        strobes.xfer = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (strobes.xfer) begin
      busy   <= 1'b1;
      bitCnt <= CNT_LOAD;
    end else if (strobes.shift) begin
      bitCnt <= bitCnt - 1'b1;
    end else if (bitStrobe && lastBit) begin
      busy   <= 1'b0;
    end
  end

  p_start_needs_cts_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(!ctsN));
  p_frame_len_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bitCnt <= CNT_LOAD));
  p_off_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy);
endmodule

// File: rtl/tx_path.sv
module tx_path
  import tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 loadStb,
  input  logic [DATA_BITS-1:0] loadData,
  input  txStrobeT             strobes,
  output logic                 txd,
  output logic                 holdFull
);
  logic [DATA_BITS-1:0] holdReg;
  logic [DATA_BITS:0]   shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdFull <= 1'b0;
      holdReg  <= '0;
    end else begin
      if (loadStb) begin
        holdFull <= 1'b1;
        holdReg  <= loadData;
      end else if (strobes.xfer) begin
        holdFull <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd      <= 1'b1;
      shiftReg <= '1;
    end else if (!en) begin
      txd      <= 1'b1;
    end else if (strobes.xfer) begin
      txd      <= 1'b0;
      shiftReg <= {1'b1, holdReg};
    end else if (strobes.shift) begin
      txd      <= shiftReg[0];
      shiftReg <= {1'b1, shiftReg[DATA_BITS:1]};
    end
  end

  p_mark_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> txd);
  p_load_fills_r7: assert property (@(posedge clk) disable iff (rst)
    loadStb |=> holdFull);
  p_start_is_space_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.xfer |=> !txd);
endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx
  import tx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int DIV_MID   = 16,
  parameter int DIV_HIGH  = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 txEnable,
  input  logic                 ctsN,
  input  logic [1:0]           rateSel,
  input  logic                 txClk,
  input  logic                 loadStb,
  input  logic [DATA_BITS-1:0] loadData,
  output logic                 txd,
  output logic                 holdReady,
  output logic                 shiftEmpty
);
  txStrobeT strobes;
  logic     bitStrobe;
  logic     holdFull;
  logic     busy;

  tx_bit_timer #(.DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH)) i_timer (
    .clk(clk), .rst(rst), .en(txEnable), .txClk(txClk),
    .rateSel(rateSel), .bitStrobe(bitStrobe)
  );

  tx_ctrl #(.DATA_BITS(DATA_BITS)) i_ctrl (
    .clk(clk), .rst(rst), .en(txEnable), .ctsN(ctsN),
    .bitStrobe(bitStrobe), .holdFull(holdFull),
    .strobes(strobes), .busy(busy)
  );

  tx_path #(.DATA_BITS(DATA_BITS)) i_path (
    .clk(clk), .rst(rst), .en(txEnable), .loadStb(loadStb),
    .loadData(loadData), .strobes(strobes),
    .txd(txd), .holdFull(holdFull)
  );

  assign holdReady  = ~holdFull;
  assign shiftEmpty = ~busy & ~holdFull;

  p_empty_needs_ready_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(shiftEmpty) |-> txd);
endmodule

// File: tb/test_serial_char_tx.sv
`timescale 1ns/1ps
module test_serial_char_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txEnable = 1'b0;
  logic       ctsN = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic       txClk = 1'b0;
  logic       loadStb = 1'b0;
  logic [7:0] loadData = '0;
  logic       txd, holdReady, shiftEmpty;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  serial_char_tx i_serial_char_tx (
    .clk(clk), .rst(rst), .txEnable(txEnable), .ctsN(ctsN),
    .rateSel(rateSel), .txClk(txClk), .loadStb(loadStb),
    .loadData(loadData), .txd(txd), .holdReady(holdReady),
    .shiftEmpty(shiftEmpty)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic fallEdge();
    @(negedge clk); txClk = 1'b1;
    @(negedge clk); @(negedge clk);
    txClk = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic loadByte(input logic [7:0] d);
    @(negedge clk); loadStb = 1'b1; loadData = d;
    @(negedge clk); loadStb = 1'b0;
  endtask

  function automatic logic frameBit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    return 1'b1;
  endfunction

  // byte already held, counter at phase zero, ctsN low
  task automatic runFrame(input logic [7:0] d, input int div, input int ctsAt);
    string req;
    req = (div == 1) ? "R3" : "R4";
    for (int e = 1; e <= 11 * div; e++) begin
      int k;
      logic exp;
      fallEdge();
      k = e / div;
      exp = (k == 0 || k >= 11) ? 1'b1 : frameBit(d, k - 1);
      chk(req, txd, exp);
      if (e == div) chk("R7", holdReady, 1'b1);
      if (e == 10 * div) chk("R8", shiftEmpty, 1'b0);
      if (e == 11 * div) chk("R8", shiftEmpty, 1'b1);
      if (e == ctsAt) ctsN = 1'b1;  // R6 raised mid-character
    end
  endtask

  initial begin
    logic [19:0] stream;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", txd, 1'b1);
    chk("R1", holdReady, 1'b1);
    chk("R1", shiftEmpty, 1'b1);

    // disabled: byte held, line stays mark
    loadByte(8'hA5);
    chk("R7", holdReady, 1'b0);
    chk("R8", shiftEmpty, 1'b0);
    repeat (3) begin fallEdge(); chk("R2", txd, 1'b1); end
    chk("R2", holdReady, 1'b0);

    // 1x: held byte then exhaustive sweep
    txEnable = 1'b1;
    runFrame(8'hA5, 1, 0);
    for (int v = 0; v < 256; v++) begin
      loadByte(v[7:0]);
      runFrame(v[7:0], 1, 0);
    end

    // R4: slower rates, phase restarted by disabling
    for (int t = 0; t < 4; t++) begin
      logic [7:0] d;
      logic [1:0] sel;
      int div;
      case (t)
        0: begin d = 8'h3C; sel = 2'd1; div = 16; end
        1: begin d = 8'h81; sel = 2'd1; div = 16; end
        2: begin d = 8'h5A; sel = 2'd2; div = 64; end
        default: begin d = 8'hC3; sel = 2'd3; div = 64; end
      endcase
      @(negedge clk); txEnable = 1'b0; rateSel = sel;
      loadByte(d);
      txEnable = 1'b1;
      runFrame(d, div, 0);
    end
    @(negedge clk); txEnable = 1'b0; rateSel = 2'd0;
    @(negedge clk); txEnable = 1'b1;

    // R6: blocked while ctsN high
    ctsN = 1'b1;
    loadByte(8'h0F);
    repeat (5) begin
      fallEdge();
      chk("R6", txd, 1'b1);
      chk("R6", holdReady, 1'b0);
    end
    ctsN = 1'b0;
    runFrame(8'h0F, 1, 0);

    // R6: ctsN rises mid-character, character completes
    loadByte(8'h66);
    runFrame(8'h66, 1, 4);
    loadByte(8'h99);
    repeat (4) begin
      fallEdge();
      chk("R6", txd, 1'b1);
      chk("R6", holdReady, 1'b0);
    end
    ctsN = 1'b0;
    runFrame(8'h99, 1, 0);

    // R9: back-to-back frames
    loadByte(8'h12);
    fallEdge();
    chk("R9", txd, 1'b0);
    loadByte(8'h34);
    stream = {1'b1, 8'h34, 1'b0, 1'b1, 8'h12, 1'b0};
    for (int e = 2; e <= 20; e++) begin
      fallEdge();
      chk("R9", txd, stream[e-1]);
      if (e == 11) chk("R9", holdReady, 1'b1);
      if (e < 21) chk("R9", shiftEmpty, 1'b0);
    end
    fallEdge();
    chk("R9", txd, 1'b1);
    chk("R8", shiftEmpty, 1'b1);

    // R2: disable mid-character aborts, line to mark
    loadByte(8'h00);
    repeat (3) begin fallEdge(); chk("R3", txd, 1'b0); end
    txEnable = 1'b0;
    @(negedge clk);
    chk("R2", txd, 1'b1);
    chk("R2", shiftEmpty, 1'b1);
    txEnable = 1'b1;
    repeat (3) begin fallEdge(); chk("R2", txd, 1'b1); end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule